// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns a 32-bit logical address from a processor into a physical address. The logical address is split into a page number and a 12-bit offset. The page number is first matched against a small, fully associative translation cache, with all entries compared in parallel. On a hit, the physical address comes back one cycle after the request is accepted, and no memory traffic takes place.

On a miss, the block fetches one page-table entry from main memory through a request/response read port. The table sits at the address held in a base register, and a length register limits which page numbers are legal. A resident entry is installed in the cache, replacing cache slots in round-robin order. A page number at or beyond the length, or a non-resident entry, produces a fault response instead of an address.

The translator handles one request at a time. Software-side configuration is two write-only registers, selected by a single select bit.

Top module: `paged_xlate`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rsp_valid_o` is 0, `mem_req_o` is 0, the length register is 0 and the cache holds no valid entry.
- R2: The page number is `req_vaddr_i[31:12]`. Bits [11:0] of the logical address appear unchanged in `rsp_paddr_o[11:0]`. On success, `rsp_paddr_o[31:12]` equals bits [31:12] of the page-table entry.
- R3: A miss issues exactly one memory read, at address base + page number × 4. `mem_addr_o` holds steady while `mem_req_o` is high and no response has arrived.
- R4: A page number that hits in the cache produces a response on the cycle after acceptance, with no memory read.
- R5: On a miss, the response appears on the cycle after the cycle in which `mem_rsp_valid_i` is high.
- R6: Bit 0 of a page-table entry is its resident flag. If the flag is 0, the response carries `rsp_fault_o`=1 and `rsp_paddr_o`=0, and the entry is not cached, so a repeat of the same page reads memory again.
- R7: A page number greater than or equal to the length register faults on the cycle after acceptance, without a memory read. This applies even when the page is cached.
- R8: The cache has 8 entries. Fills go to slots 0,1,…,7,0,… in turn, so the ninth distinct fill evicts the first.
- R9: Writing the base register (`cfg_sel_i`=0) invalidates every cache entry. A write to the length register (`cfg_sel_i`=1) leaves the cache untouched.
- R10: `req_ready_o` is 0 while a table read is outstanding. Only one translation is in flight at a time.
- R11: `rsp_valid_o` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0: table base register, 1: table length register |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| req_vaddr_i | input | 32 | Logical address |
| rsp_valid_o | output | 1 | Result strobe |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Out-of-range or non-resident page |
| mem_req_o | output | 1 | Page-table read request, held until answered |
| mem_addr_o | output | 32 | Page-table entry byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Page-table entry |

## Verification
The hardest state to reach is wrap-around of the replacement pointer, where a later fill overwrites a slot that still holds a live translation. The stimulus reaches it by first filling eight distinct pages. It then requests an evicted page and expects a memory read. Finally it requests pages in the neighbouring slots and expects them to hit without a read, which shows the fill landed in exactly one slot. Flushing and the range check on a cached page are also reached in sequence: a page is cached before the base or length register is rewritten.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } xlt_state_e;

  function automatic int unsigned clog2_min1(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/xlt_cfg.sv
module xlt_cfg #(
  parameter int unsigned AW    = 32,
  parameter int unsigned VPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [AW-1:0]    wdata_i,
  output logic [AW-1:0]    base_o,
  output logic [VPN_W:0]   len_o,
  output logic             flush_o
);
  logic [AW-1:0]  base_q;
  logic [VPN_W:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= '0;
    end else if (we_i) begin
      if (!sel_i) base_q <= wdata_i;
      else        len_q  <= wdata_i[VPN_W:0];
    end
  end

  assign base_o  = base_q;
  assign len_o   = len_q;
  assign flush_o = we_i && !sel_i;
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
  import xlt_pkg::*;
#(
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned ENTRIES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lookup_vpn_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] hit_pfn_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i
);
  localparam int unsigned PTR_W = clog2_min1(ENTRIES);

  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [PFN_W-1:0] pfn_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [PTR_W-1:0]   ptr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (vpn_q[g] == lookup_vpn_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vpn_q[g] <= '0;
        pfn_q[g] <= '0;
      end else if (fill_i && !flush_i && (ptr_q == PTR_W'(g))) begin
        vpn_q[g] <= fill_vpn_i;
        pfn_q[g] <= fill_pfn_i;
      end
    end
  end

  always_comb begin
    hit_pfn_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_pfn_o = hit_pfn_o | pfn_q[i];
  end
  assign hit_o = |hit_vec;

  // flush wins over a fill in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_i) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == PTR_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));  // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);  // R9
endmodule

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
  import xlt_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [AW-1:0]   req_vaddr_i,
  input  logic            in_range_i,
  input  logic            tlb_hit_i,
  input  logic [AW-PW-1:0] tlb_pfn_i,
  input  logic [AW-1:0]   pte_addr_i,
  output logic            rsp_valid_o,
  output logic [AW-1:0]   rsp_paddr_o,
  output logic            rsp_fault_o,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_rsp_valid_i,
  input  logic [AW-PW-1:0] pte_pfn_i,
  input  logic            pte_valid_i,
  output logic            fill_o,
  output logic [AW-PW-1:0] fill_vpn_o
);
  localparam int unsigned VPN_W = AW - PW;

  xlt_state_e       state_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PW-1:0]    off_q;
  logic             accept;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign fill_o      = (state_q == ST_WALK) && mem_rsp_valid_i && pte_valid_i;
  assign fill_vpn_o  = vpn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      vpn_q       <= '0;
      off_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_fault_o <= 1'b0;
      mem_req_o   <= 1'b0;
      mem_addr_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          vpn_q <= req_vaddr_i[AW-1:PW];
          off_q <= req_vaddr_i[PW-1:0];
          if (!in_range_i) begin
            rsp_valid_o <= 1'b1;
            rsp_fault_o <= 1'b1;
            rsp_paddr_o <= '0;
          end else if (tlb_hit_i) begin
            rsp_valid_o <= 1'b1;
            rsp_fault_o <= 1'b0;
            rsp_paddr_o <= {tlb_pfn_i, req_vaddr_i[PW-1:0]};
          end else begin
            state_q    <= ST_WALK;
            mem_req_o  <= 1'b1;
            mem_addr_o <= pte_addr_i;
          end
        end
        ST_WALK: if (mem_rsp_valid_i) begin
          state_q     <= ST_IDLE;
          mem_req_o   <= 1'b0;
          rsp_valid_o <= 1'b1;
          rsp_fault_o <= !pte_valid_i;
          rsp_paddr_o <= pte_valid_i ? {pte_pfn_i, off_q} : '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);  // R10
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);  // R11
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));  // R3
  AST_RANGE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !in_range_i) |=> (!mem_req_o && rsp_valid_o && rsp_fault_o));  // R7
  AST_HIT_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_range_i && tlb_hit_i) |=> (!mem_req_o && rsp_valid_o && !rsp_fault_o));  // R4
  AST_MISS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rsp_valid_i) |=> (rsp_valid_o && !mem_req_o));  // R5
endmodule

// File: rtl/paged_xlate.sv
module paged_xlate #(
  parameter int unsigned AW      = 32,
  parameter int unsigned PW      = 12,
  parameter int unsigned ENTRIES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_vaddr_i,
  output logic          rsp_valid_o,
  output logic [AW-1:0] rsp_paddr_o,
  output logic          rsp_fault_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [AW-1:0] mem_rsp_data_i
);
  localparam int unsigned VPN_W = AW - PW;
  localparam int unsigned PAD_W = AW - VPN_W - 2;

  logic [AW-1:0]    base;
  logic [VPN_W:0]   len;
  logic             flush;
  logic [VPN_W-1:0] vpn;
  logic             in_range;
  logic [AW-1:0]    pte_addr;
  logic             tlb_hit;
  logic [VPN_W-1:0] tlb_pfn;
  logic             fill;
  logic [VPN_W-1:0] fill_vpn;
  logic             unused_bits;

  assign vpn         = req_vaddr_i[AW-1:PW];
  assign in_range    = {1'b0, vpn} < len;
  assign pte_addr    = base + {{PAD_W{1'b0}}, vpn, 2'b00};
  assign unused_bits = ^{mem_rsp_data_i[PW-1:1], cfg_wdata_i[AW-1:VPN_W+1]};

  xlt_cfg #(.AW(AW), .VPN_W(VPN_W)) cfg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .base_o  (base),
    .len_o   (len),
    .flush_o (flush)
  );

  xlt_tlb #(.VPN_W(VPN_W), .PFN_W(VPN_W), .ENTRIES(ENTRIES)) tlb_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .lookup_vpn_i (vpn),
    .hit_o        (tlb_hit),
    .hit_pfn_o    (tlb_pfn),
    .fill_i       (fill),
    .fill_vpn_i   (fill_vpn),
    .fill_pfn_i   (mem_rsp_data_i[AW-1:PW])
  );

  xlt_ctrl #(.AW(AW), .PW(PW)) ctrl_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_vaddr_i     (req_vaddr_i),
    .in_range_i      (in_range),
    .tlb_hit_i       (tlb_hit),
    .tlb_pfn_i       (tlb_pfn),
    .pte_addr_i      (pte_addr),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_paddr_o     (rsp_paddr_o),
    .rsp_fault_o     (rsp_fault_o),
    .mem_req_o       (mem_req_o),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .pte_pfn_i       (mem_rsp_data_i[AW-1:PW]),
    .pte_valid_i     (mem_rsp_data_i[0]),
    .fill_o          (fill),
    .fill_vpn_o      (fill_vpn)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (req_ready_o && !mem_req_o));  // R1
endmodule

// File: tb/paged_xlate_tb_top.sv
`timescale 1ns/1ps
module paged_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault, mem_req;
  logic [31:0] rsp_paddr, mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int n_vec = 0, n_fail = 0, n_reads = 0, wait_cnt = 0;
  logic [31:0] last_addr = '0, cur_base = '0;
  bit done = 0;

  always #4 clk = ~clk;

  paged_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data)
  );

  // table A at 0x10000: frame 0x80+3*vpn, vpn 5 non-resident; table B at 0x20000: frame 0x300+vpn
  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [31:0] idx;
    if (a >= 32'h10000 && a < 32'h10040) begin
      idx = (a - 32'h10000) >> 2;
      return {20'h80 + 20'(3 * idx), 11'b0, (idx != 5)};
    end
    if (a >= 32'h20000 && a < 32'h20040) begin
      idx = (a - 32'h20000) >> 2;
      return {20'h300 + 20'(idx), 12'h001};
    end
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    if (mem_req && !mem_rsp_valid) begin
      if (wait_cnt == 1) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pte_of(mem_addr);
        last_addr     = mem_addr;
        wait_cnt      = 0;
      end else wait_cnt++;
    end else mem_rsp_valid = 1'b0;
  end

  always @(posedge clk) if (mem_req && mem_rsp_valid) n_reads++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!sel) cur_base = d;
  endtask

  task automatic xlate(input logic [31:0] va, output logic [31:0] pa, output logic f,
                       output int lat, output int nrd, output bit busy);
    int r0;
    r0 = n_reads;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; busy = 0;
    while (!rsp_valid && lat < 20) begin
      if (!req_ready) busy = 1;
      @(negedge clk);
      lat++;
    end
    pa = rsp_paddr; f = rsp_fault;
    @(negedge clk);
    chk(!rsp_valid, "R11 pulse", {31'b0, rsp_valid}, 32'h0);
    nrd = n_reads - r0;
  endtask

  // {expect_read, expect_fault, vaddr}
  localparam logic [33:0] VEC [20] = '{
    {1'b1, 1'b0, 32'h0000_0123}, {1'b0, 1'b0, 32'h0000_0456},
    {1'b1, 1'b1, 32'h0000_5010}, {1'b1, 1'b1, 32'h0000_5020},
    {1'b0, 1'b1, 32'h0001_0ABC}, {1'b1, 1'b0, 32'h0000_FFFF},
    {1'b0, 1'b0, 32'h0000_F001}, {1'b1, 1'b0, 32'h0000_10A0},
    {1'b1, 1'b0, 32'h0000_20A0}, {1'b1, 1'b0, 32'h0000_30A0},
    {1'b1, 1'b0, 32'h0000_40A0}, {1'b1, 1'b0, 32'h0000_60A0},
    {1'b1, 1'b0, 32'h0000_70A0}, {1'b1, 1'b0, 32'h0000_80A0},
    {1'b1, 1'b0, 32'h0000_90A0}, {1'b1, 1'b0, 32'h0000_0777},
    {1'b0, 1'b0, 32'h0000_2777}, {1'b0, 1'b0, 32'h0000_8777},
    {1'b0, 1'b0, 32'h0000_9777}, {1'b1, 1'b0, 32'h0000_1777}
  };

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, va, exp_pa;
    logic f;
    int lat, nrd;
    bit busy;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 ready", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk(mem_req === 1'b0, "R1 mem_req", {31'b0, mem_req}, 32'h0);
    rst_n = 1'b1;
    // R1: length 0 after reset, so page 0 faults with no read
    xlate(32'h0000_0001, pa, f, lat, nrd, busy);
    chk(f === 1'b1 && nrd == 0, "R1 len zero", {31'b0, f}, 32'h1);

    cfg_write(1'b0, 32'h0001_0000);
    cfg_write(1'b1, 32'd16);

    for (int i = 0; i < 20; i++) begin
      va = VEC[i][31:0];
      xlate(va, pa, f, lat, nrd, busy);
      exp_pa = VEC[i][32] ? 32'h0 : {20'h80 + 20'(3 * va[31:12]), va[11:0]};
      chk(pa === exp_pa, "R2/R6 paddr", pa, exp_pa);
      chk(f === VEC[i][32], "R6/R7 fault", {31'b0, f}, {31'b0, VEC[i][32]});
      chk(nrd == int'(VEC[i][33]), "R4/R8 reads", nrd, {31'b0, VEC[i][33]});
      chk(lat == (VEC[i][33] ? 3 : 1), "R4/R5 latency", lat, VEC[i][33] ? 3 : 1);
      if (VEC[i][33]) begin
        chk(last_addr === cur_base + {va[31:12], 2'b00}, "R3 pte addr", last_addr,
            cur_base + {va[31:12], 2'b00});
        chk(busy, "R10 busy", {31'b0, busy}, 32'h1);
      end
    end

    // R9: length write keeps cache, base write flushes it
    cfg_write(1'b1, 32'd16);
    xlate(32'h0000_9111, pa, f, lat, nrd, busy);
    chk(nrd == 0 && pa === 32'h0009B111, "R9 len write keeps", pa, 32'h0009B111);
    cfg_write(1'b0, 32'h0002_0000);
    xlate(32'h0000_9111, pa, f, lat, nrd, busy);
    chk(nrd == 1 && pa === 32'h00309111, "R9 base flush", pa, 32'h00309111);
    chk(last_addr === 32'h0002_0024, "R3 new base addr", last_addr, 32'h0002_0024);

    // R7: cached page beyond a shrunk length still faults, no read
    xlate(32'h0000_2abc, pa, f, lat, nrd, busy);
    chk(f === 1'b0 && pa === 32'h00302abc, "R2 table B", pa, 32'h00302abc);
    cfg_write(1'b1, 32'd2);
    xlate(32'h0000_2abc, pa, f, lat, nrd, busy);
    chk(f === 1'b1 && nrd == 0 && lat == 1, "R7 cached out of range", {31'b0, f}, 32'h1);
    chk(pa === 32'h0, "R7 paddr zero", pa, 32'h0);
    xlate(32'h0000_1fff, pa, f, lat, nrd, busy);
    chk(f === 1'b0 && pa === 32'h00301fff, "R7 last legal page", pa, 32'h00301fff);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule